// File: doc/BRIEF.md
# Dual Synthesizer Lock Detector

This block watches the phase-frequency detectors of two synthesizer loops, a main loop and an auxiliary loop, and reduces them to one lock flag. Everything runs on the reference input clock. A loop's phase error is taken as the width of its detector's up or down pulse. That width is counted in reference clock edges. An error of one reference period or more clears that loop's lock status at once. A clean comparison window sets the status again.

Each loop's power state comes from a hardware power pin XORed with a software power-down bit for that loop. A loop that is powered down is left out of the combined flag, and its lock status is held at unlocked. When both loops are down, the flag is low. When a loop comes back up, the block issues a one-cycle resync pulse so that the dividers of that loop restart in phase.

Top module: `dual_lock_detect`

## Requirements
- R1: Each loop is active exactly when `pwr_pin_i` XOR its power-down bit is 1. With the pin at 0, a bit value of 1 means the loop is powered up. The active outputs follow these inputs combinationally.
- R2: With both loops active, `lock_o` is 1 only when both loops are locked. A loop that has just been reactivated holds `lock_o` low even while the other loop is locked.
- R3: With one loop inactive, `lock_o` follows the active loop alone. Detector pulses of the inactive loop have no effect on `lock_o`.
- R4: With both loops inactive, `lock_o` is 0.
- R5: A loop's resync output is a registered pulse exactly one clock wide. It is high in the cycle after the first rising edge at which that loop is sampled active, having been sampled inactive on the edge before or being in reset.
- R6: A phase error is up or down sampled high on ERR_SAMPLES (default 2) consecutive active edges. It clears that loop's lock at that edge. A shorter pulse has no effect.
- R7: A loop becomes locked at the end of a window of LOCK_WIN (default 4) active edges with no phase error. The first window starts at the first active edge. After an error, lock returns within 2*LOCK_WIN edges of clean input.
- R8: While a loop is inactive its lock status is unlocked. After reactivation it needs a full clean window before it counts as locked.
- R9: During reset `lock_o` and both resync outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | Reference input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_pin_i | input | 1 | Hardware power pin, shared by both loops |
| main_pd_i | input | 1 | Software power-down bit for the main loop |
| aux_pd_i | input | 1 | Software power-down bit for the auxiliary loop |
| main_up_i | input | 1 | Main detector up pulse |
| main_dn_i | input | 1 | Main detector down pulse |
| aux_up_i | input | 1 | Auxiliary detector up pulse |
| aux_dn_i | input | 1 | Auxiliary detector down pulse |
| main_active_o | output | 1 | Main loop powered up |
| aux_active_o | output | 1 | Auxiliary loop powered up |
| main_resync_o | output | 1 | Divider resync pulse for the main loop |
| aux_resync_o | output | 1 | Divider resync pulse for the auxiliary loop |
| lock_o | output | 1 | Combined lock flag |

## Verification
The assertions check the following on every cycle:
- `lock_o` is low whenever both loops are down.
- A resync pulse is never wider than one cycle, and it only follows an active sample.
- A loop that is down has its lock status cleared on the next edge.
- An over-width detector pulse always clears that loop's status on the next edge.
- `lock_o` never stands high over an unlocked active loop.

The bench's scenarios are needed for the rest:
- The exact edge at which lock returns after a clean window.
- The width boundary between a tolerated pulse and an error.
- The exact resync timing over all eight power input combinations.
- The fact that an inactive loop's pulses leave the flag untouched.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned MAIN_IDX  = 0;
  localparam int unsigned AUX_IDX   = 1;
endpackage

// File: rtl/dls_pwr_track.sv
module dls_pwr_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pd_i,
  output logic active_o,
  output logic resync_o
);
  logic act_q, resync_q;

  // hardware pin inverts the polarity of the software bit
  assign active_o = pin_i ^ pd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      resync_q <= 1'b0;
    end else begin
      act_q    <= active_o;
      resync_q <= active_o & ~act_q;
    end
  end

  assign resync_o = resync_q;
endmodule

// File: rtl/dls_loop_mon.sv
module dls_loop_mon #(
  parameter int unsigned ERR_SAMPLES = 2,
  parameter int unsigned LOCK_WIN    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic up_i,
  input  logic dn_i,
  output logic locked_o
);
  localparam int unsigned WID_W = (ERR_SAMPLES > 1) ? $clog2(ERR_SAMPLES) : 1;
  localparam int unsigned WIN_W = (LOCK_WIN > 1) ? $clog2(LOCK_WIN) : 1;
  localparam logic [WID_W-1:0] WID_MAX  = WID_W'(ERR_SAMPLES - 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOCK_WIN - 1);

  logic [WID_W-1:0] wid_cnt;
  logic [WIN_W-1:0] win_cnt;
  logic             err_seen, locked_q;
  logic             pulse, err_now;

  assign pulse   = up_i | dn_i;
  assign err_now = active_i & pulse & (wid_cnt == WID_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_cnt  <= '0;
      win_cnt  <= '0;
      err_seen <= 1'b0;
      locked_q <= 1'b0;
    end else if (!active_i) begin
      wid_cnt  <= '0;
      win_cnt  <= '0;
      err_seen <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      if (!pulse)                wid_cnt <= '0;
      else if (wid_cnt != WID_MAX) wid_cnt <= wid_cnt + 1'b1;
      if (win_cnt == WIN_LAST) begin
        win_cnt  <= '0;
        err_seen <= 1'b0;
        locked_q <= ~(err_seen | err_now);
      end else begin
        win_cnt <= win_cnt + 1'b1;
        if (err_now) begin
          err_seen <= 1'b1;
          locked_q <= 1'b0;
        end
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/dual_lock_detect.sv
module dual_lock_detect #(
  parameter int unsigned ERR_SAMPLES = 2,
  parameter int unsigned LOCK_WIN    = 4
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic pwr_pin_i,
  input  logic main_pd_i,
  input  logic aux_pd_i,
  input  logic main_up_i,
  input  logic main_dn_i,
  input  logic aux_up_i,
  input  logic aux_dn_i,
  output logic main_active_o,
  output logic aux_active_o,
  output logic main_resync_o,
  output logic aux_resync_o,
  output logic lock_o
);
  import dls_pkg::*;

  logic [NUM_LOOPS-1:0] pd_v, up_v, dn_v, act_v, resync_v, locked_v, ok_v;

  assign pd_v[MAIN_IDX] = main_pd_i;
  assign pd_v[AUX_IDX]  = aux_pd_i;
  assign up_v[MAIN_IDX] = main_up_i;
  assign up_v[AUX_IDX]  = aux_up_i;
  assign dn_v[MAIN_IDX] = main_dn_i;
  assign dn_v[AUX_IDX]  = aux_dn_i;

  for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
    dls_pwr_track u_pwr (
      .clk_i    (ref_clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pwr_pin_i),
      .pd_i     (pd_v[i]),
      .active_o (act_v[i]),
      .resync_o (resync_v[i])
    );
    dls_loop_mon #(
      .ERR_SAMPLES (ERR_SAMPLES),
      .LOCK_WIN    (LOCK_WIN)
    ) u_mon (
      .clk_i    (ref_clk_i),
      .rst_ni   (rst_ni),
      .active_i (act_v[i]),
      .up_i     (up_v[i]),
      .dn_i     (dn_v[i]),
      .locked_o (locked_v[i])
    );
    // a powered-down loop does not veto the combined flag
    assign ok_v[i] = ~act_v[i] | locked_v[i];
  end

  assign lock_o        = (|act_v) & (&ok_v);
  assign main_active_o = act_v[MAIN_IDX];
  assign aux_active_o  = act_v[AUX_IDX];
  assign main_resync_o = resync_v[MAIN_IDX];
  assign aux_resync_o  = resync_v[AUX_IDX];
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int unsigned ERR_SAMPLES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] act_i,
  input logic [1:0] up_i,
  input logic [1:0] dn_i,
  input logic [1:0] locked_i,
  input logic [1:0] resync_i,
  input logic       lock_i
);
  localparam int unsigned RUN_W = $clog2(ERR_SAMPLES + 1);
  localparam logic [RUN_W-1:0] RUN_HIT = RUN_W'(ERR_SAMPLES - 1);

  // R4
  lock_low_when_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == 2'b00) |-> !lock_i);

  for (genvar i = 0; i < 2; i++) begin : g_chk
    logic [RUN_W-1:0] run_cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           run_cnt <= '0;
      else if (!act_i[i] || !(up_i[i] | dn_i[i])) run_cnt <= '0;
      else if (run_cnt != RUN_HIT)           run_cnt <= run_cnt + 1'b1;
    end

    // R5
    resync_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resync_i[i] |=> !resync_i[i]);
    // R5
    resync_after_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resync_i[i] |-> $past(act_i[i]));
    // R8
    down_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !act_i[i] |=> !locked_i[i]);
    // R6
    wide_pulse_unlocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i[i] && (up_i[i] | dn_i[i]) && run_cnt == RUN_HIT) |=> !locked_i[i]);
    // R2
    lock_needs_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_i && act_i[i]) |-> locked_i[i]);
  end
endmodule

bind dual_lock_detect dls_checker #(.ERR_SAMPLES(ERR_SAMPLES)) u_dls_checker (
  .clk_i    (ref_clk_i),
  .rst_ni   (rst_ni),
  .act_i    (act_v),
  .up_i     (up_v),
  .dn_i     (dn_v),
  .locked_i (locked_v),
  .resync_i (resync_v),
  .lock_i   (lock_o)
);

// File: tb/dual_lock_detect_bench.sv
`timescale 1ns/1ps
module dual_lock_detect_bench;
  localparam int ERR = 2;
  localparam int WIN = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic pin, mpd, apd, mup, mdn, aup, adn;
  logic m_act, a_act, m_rs, a_rs, lock;
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  always #10 clk = ~clk;

  dual_lock_detect #(.ERR_SAMPLES(ERR), .LOCK_WIN(WIN)) u_dual_lock_detect (
    .ref_clk_i(clk), .rst_ni(rst_n), .pwr_pin_i(pin), .main_pd_i(mpd), .aux_pd_i(apd),
    .main_up_i(mup), .main_dn_i(mdn), .aux_up_i(aup), .aux_dn_i(adn),
    .main_active_o(m_act), .aux_active_o(a_act), .main_resync_o(m_rs),
    .aux_resync_o(a_rs), .lock_o(lock)
  );

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    {pin, mpd, apd, mup, mdn, aup, adn} = '0;
    mpd = 1'b1;
    apd = 1'b1;
    @(negedge clk);
    tick(2);
    chk("R9 lock in reset", {1'b0, lock}, 2'b00);
    chk("R9 resync in reset", {m_rs, a_rs}, 2'b00);
    {mpd, apd} = 2'b00;
    rst_n = 1'b1;
    tick(1);

    // sweep all power input combinations from the all-down state
    for (int c = 0; c < 8; c++) begin
      logic ma, aa;
      {pin, mpd, apd} = 3'b000;
      tick(2);
      chk("R4 both down", {1'b0, lock}, 2'b00);
      {pin, mpd, apd} = c[2:0];
      ma = c[2] ^ c[1];
      aa = c[2] ^ c[0];
      #1;
      chk("R1 active flags", {m_act, a_act}, {ma, aa});
      tick(1);
      chk("R5 resync pulse", {m_rs, a_rs}, {ma, aa});
      tick(1);
      chk("R5 resync one cycle", {m_rs, a_rs}, 2'b00);
      tick(WIN - 3);
      chk("R7 not yet locked", {1'b0, lock}, 2'b00);
      tick(1);
      chk("R7 locked after window", {1'b0, lock}, {1'b0, ma | aa});
    end

    // pulse width sweep with both loops active
    {pin, mpd, apd} = 3'b011;
    tick(WIN + 1);
    chk("R2 both locked", {1'b0, lock}, 2'b01);
    for (int t = 0; t < 2; t++) begin
      for (int w = 1; w <= 4; w++) begin
        if (t == 0) mup = 1'b1; else adn = 1'b1;
        for (int k = 1; k <= w; k++) begin
          tick(1);
          chk("R6 pulse width vs lock", {1'b0, lock}, {1'b0, (k < ERR) ? 1'b1 : 1'b0});
        end
        mup = 1'b0;
        adn = 1'b0;
        tick(2 * WIN + 1);
        chk("R7 relock after clean input", {1'b0, lock}, 2'b01);
      end
    end

    // aux down: its pulses are ignored, main alone decides
    apd = 1'b0;
    #1;
    chk("R1 aux down", {m_act, a_act}, 2'b10);
    chk("R3 main alone", {1'b0, lock}, 2'b01);
    aup = 1'b1;
    adn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      chk("R3 inactive pulses ignored", {1'b0, lock}, 2'b01);
    end
    aup = 1'b0;
    adn = 1'b0;
    mdn = 1'b1;
    tick(ERR);
    chk("R3 main error drops lock", {1'b0, lock}, 2'b00);
    mdn = 1'b0;
    tick(2 * WIN + 1);
    chk("R3 main relocks alone", {1'b0, lock}, 2'b01);

    // power-cycle main: status must restart unlocked
    mpd = 1'b0;
    tick(1);
    chk("R4 both down again", {1'b0, lock}, 2'b00);
    mpd = 1'b1;
    #1;
    chk("R8 unlocked on reactivation", {1'b0, lock}, 2'b00);
    tick(1);
    chk("R5 main resync", {m_rs, a_rs}, 2'b10);
    tick(WIN - 2);
    chk("R8 needs full window", {1'b0, lock}, 2'b00);
    tick(1);
    chk("R8 locked after window", {1'b0, lock}, 2'b01);

    // aux reactivated while main locked
    apd = 1'b1;
    tick(1);
    chk("R5 aux resync", {m_rs, a_rs}, 2'b01);
    chk("R2 new loop vetoes lock", {1'b0, lock}, 2'b00);
    tick(WIN - 2);
    chk("R2 still vetoed", {1'b0, lock}, 2'b00);
    tick(1);
    chk("R2 both locked again", {1'b0, lock}, 2'b01);

    finish_run();
  end
endmodule